// File: doc/BRIEF.md
# Fieldbus identifier frame receiver

This block sits behind the line decoder of a fieldbus agent and picks out the identifier frames that the bus master sends. The decoder reports three things: that it has found the two-byte start sequence, each decoded byte, and that it has found the end delimiter. Between the start sequence and the end delimiter, the receiver expects exactly five bytes in this order: one control byte, the variable identifier with its most significant byte first, and a 16-bit check value with its high byte first. The whole frame on the line is therefore eight bytes long.

The receiver runs a 16-bit CRC over the control and identifier bytes. The CRC polynomial, the initial value and the final XOR are all parameters. At the end delimiter the receiver compares the byte count and the check value. A good frame gives a one-cycle `frame_ok_o` pulse and loads the control and identifier outputs. A bad frame gives a one-cycle `frame_err_o` pulse and leaves the outputs alone. The receiver only sees byte strobes, never line bit times, so it works unchanged at every line rate the bus uses. Its state register is built so that an encoding outside the legal set falls back to idle.

Top module: `fidr_rx`

## Requirements
- R1: After reset, `frame_ok_o` and `frame_err_o` are low, and `ctrl_o` and `ident_o` are zero.
- R2: A frame is `sof_i`, then five strobed bytes (control, identifier high, identifier low, check high, check low), then `eof_i`. If it is well formed, `frame_ok_o` is high for exactly the one cycle after the clock edge that samples `eof_i`. In that same cycle `ctrl_o` and `ident_o` (most significant byte first) show the new values.
- R3: The check value is a CRC taken most significant bit first over the control and identifier bytes. Each byte is XORed into bits 15:8. The register starts at `CRC_INIT`, shifts with polynomial `CRC_POLY`, and is XORed with `CRC_XOROUT` at the end. If it differs from the received check value, the receiver pulses `frame_err_o` instead of `frame_ok_o`.
- R4: An `eof_i` that arrives after fewer than five bytes pulses `frame_err_o`. The receiver then returns to idle, and the next complete frame is accepted.
- R5: An `eof_i` that arrives after more than five bytes pulses `frame_err_o`.
- R6: A `sof_i` that arrives in the middle of a frame pulses `frame_err_o` in the following cycle. It then starts reception of a new frame, which is accepted if it is well formed.
- R7: In idle, byte strobes and `eof_i` have no effect. No pulse appears and `ctrl_o` and `ident_o` keep their values.
- R8: `ctrl_o` and `ident_o` change only in the cycle that `frame_ok_o` is high. A rejected frame leaves both unchanged.
- R9: `sof_i` takes priority over `eof_i`, and both take priority over a byte strobe. A byte strobed in the same cycle as `sof_i` or `eof_i` is not counted.
- R10: Any number of idle cycles between byte strobes leaves the result unchanged. This is what lets one receiver serve every line rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Strobe for a decoded byte |
| byte_i | input | 8 | Decoded byte |
| sof_i | input | 1 | Start sequence detected |
| eof_i | input | 1 | End delimiter detected |
| ctrl_o | output | 8 | Control byte of the last good frame |
| ident_o | output | 8*ID_BYTES | Identifier of the last good frame |
| frame_ok_o | output | 1 | One-cycle pulse for a good frame |
| frame_err_o | output | 1 | One-cycle pulse for a rejected or aborted frame |

## Verification
The bench does not use the default CRC settings. It builds the receiver with `CRC_POLY` 16'h8005, `CRC_INIT` 16'h0000 and `CRC_XOROUT` 16'hFFFF, so a correct result shows that all three parameters reach the CRC datapath and the final compare. The identifier stays at two bytes. With that width, a five-byte body sits next to the short (four-byte) and long (six-byte) cases, and the high-first ordering of the identifier can be seen on `ident_o`. The gap between strobes is varied from zero to twenty cycles, which stands in for the slower line rates.

// File: rtl/fidr_pkg.sv
`timescale 1ns/1ps
package fidr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RECV = 2'b01
  } fidr_state_e;

  // One byte through a 16-bit MSB-first CRC.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc,
                                             input logic [7:0]  d,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/fidr_seq.sv
`timescale 1ns/1ps
module fidr_seq
  import fidr_pkg::*;
#(
  parameter int BODY_BYTES = 5,
  localparam int CW = $clog2(BODY_BYTES + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sof_i,
  input  logic          eof_i,
  input  logic          byte_vld_i,
  output logic          take_o,
  output logic [CW-1:0] idx_o,
  output logic          close_o,
  output logic          abort_o,
  output logic          len_ok_o
);

  localparam logic [CW-1:0] LAST = CW'(BODY_BYTES + 1);

  fidr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = ST_IDLE;
    case (state_q)
      ST_IDLE: state_d = sof_i ? ST_RECV : ST_IDLE;
      ST_RECV: begin
        if (sof_i)      state_d = ST_RECV;
        else if (eof_i) state_d = ST_IDLE;
        else            state_d = ST_RECV;
      end
      default: state_d = ST_IDLE;  // illegal code recovers
    endcase
  end

  assign take_o   = (state_q == ST_RECV) && byte_vld_i && !sof_i && !eof_i;
  assign abort_o  = (state_q == ST_RECV) && sof_i;
  assign close_o  = (state_q == ST_RECV) && eof_i && !sof_i;
  assign len_ok_o = (cnt_q == CW'(BODY_BYTES));
  assign idx_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (sof_i)                        cnt_q <= '0;
      else if (take_o && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r7_idle_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !take_o && !close_o);

endmodule

// File: rtl/fidr_crc.sv
`timescale 1ns/1ps
module fidr_crc
  import fidr_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (clr_i)  crc_o <= CRC_INIT;
    else if (en_i)   crc_o <= crc16_byte(crc_o, data_i, CRC_POLY);
  end

endmodule

// File: rtl/fidr_fields.sv
`timescale 1ns/1ps
module fidr_fields #(
  parameter int HDR_BYTES  = 3,
  parameter int BODY_BYTES = 5,
  localparam int CW = $clog2(BODY_BYTES + 2),
  localparam int HW = 8 * HDR_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [CW-1:0] idx_i,
  input  logic [7:0]    data_i,
  output logic [HW-1:0] hdr_o,
  output logic [15:0]   rxcrc_o
);

  logic in_hdr, in_crc;
  assign in_hdr = idx_i < CW'(HDR_BYTES);
  assign in_crc = !in_hdr && (idx_i < CW'(BODY_BYTES));

  // High byte first: shift in from the bottom.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o   <= '0;
      rxcrc_o <= '0;
    end else if (take_i) begin
      if (in_hdr)      hdr_o   <= {hdr_o[HW-9:0], data_i};
      else if (in_crc) rxcrc_o <= {rxcrc_o[7:0], data_i};
    end
  end

endmodule

// File: rtl/fidr_rx.sv
`timescale 1ns/1ps
module fidr_rx #(
  parameter int          ID_BYTES   = 2,
  parameter logic [15:0] CRC_POLY   = 16'h1021,
  parameter logic [15:0] CRC_INIT   = 16'hFFFF,
  parameter logic [15:0] CRC_XOROUT = 16'h0000,
  localparam int ID_W = 8 * ID_BYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic            sof_i,
  input  logic            eof_i,
  output logic [7:0]      ctrl_o,
  output logic [ID_W-1:0] ident_o,
  output logic            frame_ok_o,
  output logic            frame_err_o
);

  localparam int HDR_BYTES  = 1 + ID_BYTES;
  localparam int BODY_BYTES = HDR_BYTES + 2;
  localparam int CW         = $clog2(BODY_BYTES + 2);
  localparam int HW         = 8 * HDR_BYTES;

  logic          take, close, abort, len_ok;
  logic [CW-1:0] idx;
  logic [15:0]   crc, rxcrc;
  logic [HW-1:0] hdr;
  logic          good;

  fidr_seq #(.BODY_BYTES(BODY_BYTES)) u_seq (
    .clk_i, .rst_ni, .sof_i, .eof_i, .byte_vld_i,
    .take_o(take), .idx_o(idx), .close_o(close),
    .abort_o(abort), .len_ok_o(len_ok)
  );

  fidr_crc #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_crc (
    .clk_i, .rst_ni, .clr_i(sof_i),
    .en_i(take && (idx < CW'(HDR_BYTES))),
    .data_i(byte_i), .crc_o(crc)
  );

  fidr_fields #(.HDR_BYTES(HDR_BYTES), .BODY_BYTES(BODY_BYTES)) u_fields (
    .clk_i, .rst_ni, .take_i(take), .idx_i(idx), .data_i(byte_i),
    .hdr_o(hdr), .rxcrc_o(rxcrc)
  );

  assign good = close && len_ok && ((crc ^ CRC_XOROUT) == rxcrc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_ok_o  <= 1'b0;
      frame_err_o <= 1'b0;
      ctrl_o      <= '0;
      ident_o     <= '0;
    end else begin
      frame_ok_o  <= good;
      frame_err_o <= (close && !good) || abort;
      if (good) begin
        ctrl_o  <= hdr[HW-1 -: 8];
        ident_o <= hdr[ID_W-1:0];
      end
    end
  end

  a_r2_ok_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ok_o && frame_err_o));
  a_r2_ok_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |-> $past(eof_i) && !$past(sof_i));
  a_r6_abort_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> frame_err_o);
  a_r8_id_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ident_o) || !$stable(ctrl_o) |-> frame_ok_o);

endmodule

// File: tb/tb_fidr_rx.sv
`timescale 1ns/1ps
module tb_fidr_rx;

  localparam logic [15:0] POLY = 16'h8005;
  localparam logic [15:0] INIT = 16'h0000;
  localparam logic [15:0] XOUT = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        sof = 1'b0, eof = 1'b0;
  logic [7:0]  ctrl;
  logic [15:0] ident;
  logic        ok, err;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  fidr_rx #(.ID_BYTES(2), .CRC_POLY(POLY), .CRC_INIT(INIT), .CRC_XOROUT(XOUT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .sof_i(sof), .eof_i(eof), .ctrl_o(ctrl), .ident_o(ident),
    .frame_ok_o(ok), .frame_err_o(err)
  );

  function automatic logic [15:0] ref_crc(input logic [7:0] c, input logic [15:0] id);
    logic [15:0] r;
    logic [7:0]  b [3];
    b[0] = c; b[1] = id[15:8]; b[2] = id[7:0];
    r = INIT;
    for (int k = 0; k < 3; k++) begin
      r = r ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++) r = r[15] ? ((r << 1) ^ POLY) : (r << 1);
    end
    return r ^ XOUT;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input int gap);
    @(negedge clk); byte_vld = 1'b1; byte_d = b;
    @(negedge clk); byte_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic put_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic send_body(input logic [7:0] c, input logic [15:0] id,
                           input logic [15:0] cr, input int gap);
    put_byte(c, gap); put_byte(id[15:8], gap); put_byte(id[7:0], gap);
    put_byte(cr[15:8], gap); put_byte(cr[7:0], gap);
  endtask

  task automatic end_check(input string req, input logic exp_ok, input logic exp_err,
                           input logic with_byte);
    @(negedge clk); eof = 1'b1; byte_vld = with_byte; byte_d = 8'hA5;
    @(posedge clk); #1;
    check({req, " ok"}, 32'(ok), 32'(exp_ok));
    check({req, " err"}, 32'(err), 32'(exp_err));
    @(negedge clk); eof = 1'b0; byte_vld = 1'b0;
    @(posedge clk); #1;
    check({req, " pulse width"}, 32'(ok | err), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 ok", 32'(ok), 0);
    check("R1 err", 32'(err), 0);
    check("R1 ctrl", 32'(ctrl), 0);
    check("R1 ident", 32'(ident), 0);
  endtask

  task automatic t_good();
    put_sof();
    send_body(8'h03, 16'h1234, ref_crc(8'h03, 16'h1234), 0);
    end_check("R2 good", 1, 0, 0);
    check("R2 ctrl", 32'(ctrl), 32'h03);
    check("R2 ident msb first", 32'(ident), 32'h1234);
  endtask

  task automatic t_slow();
    put_sof();
    send_body(8'h81, 16'hBEEF, ref_crc(8'h81, 16'hBEEF), 20);
    end_check("R10 gapped", 1, 0, 0);
    check("R10 ident", 32'(ident), 32'hBEEF);
    check("R10 ctrl", 32'(ctrl), 32'h81);
  endtask

  task automatic t_crc_bad();
    put_sof();
    send_body(8'h05, 16'h4321, ref_crc(8'h05, 16'h4321) ^ 16'h0100, 1);
    end_check("R3 bad crc", 0, 1, 0);
    check("R8 ident kept", 32'(ident), 32'hBEEF);
    check("R8 ctrl kept", 32'(ctrl), 32'h81);
  endtask

  task automatic t_short();
    put_sof();
    put_byte(8'h01, 0); put_byte(8'h02, 0); put_byte(8'h03, 0); put_byte(8'h04, 0);
    end_check("R4 short", 0, 1, 0);
    put_sof();
    send_body(8'h11, 16'h0042, ref_crc(8'h11, 16'h0042), 0);
    end_check("R4 recovers", 1, 0, 0);
    check("R4 ident", 32'(ident), 32'h0042);
  endtask

  task automatic t_long();
    logic [15:0] cr;
    cr = ref_crc(8'h22, 16'h5566);
    put_sof();
    send_body(8'h22, 16'h5566, cr, 0);
    put_byte(8'h00, 0);
    end_check("R5 long", 0, 1, 0);
    check("R5 ident kept", 32'(ident), 32'h0042);
  endtask

  task automatic t_restart();
    put_sof();
    put_byte(8'h33, 0); put_byte(8'h77, 0);
    @(negedge clk); sof = 1'b1;
    @(posedge clk); #1;
    check("R6 abort err", 32'(err), 1);
    check("R6 abort ok", 32'(ok), 0);
    @(negedge clk); sof = 1'b0;
    send_body(8'h44, 16'hA0B1, ref_crc(8'h44, 16'hA0B1), 0);
    end_check("R6 restart frame", 1, 0, 0);
    check("R6 ident", 32'(ident), 32'hA0B1);
  endtask

  task automatic t_idle();
    send_body(8'h55, 16'h9999, ref_crc(8'h55, 16'h9999), 0);
    end_check("R7 idle eof", 0, 0, 0);
    check("R7 ident kept", 32'(ident), 32'hA0B1);
    check("R7 ctrl kept", 32'(ctrl), 32'h44);
  endtask

  task automatic t_prio();
    // Byte strobed together with sof must not be counted.
    @(negedge clk); sof = 1'b1; byte_vld = 1'b1; byte_d = 8'hEE;
    @(negedge clk); sof = 1'b0; byte_vld = 1'b0;
    send_body(8'h66, 16'h0F0F, ref_crc(8'h66, 16'h0F0F), 0);
    end_check("R9 byte with eof ignored", 1, 0, 1);
    check("R9 ident", 32'(ident), 32'h0F0F);
    // sof and eof together mid-frame: treated as restart.
    put_sof();
    put_byte(8'h01, 0);
    @(negedge clk); sof = 1'b1; eof = 1'b1;
    @(posedge clk); #1;
    check("R9 sof over eof err", 32'(err), 1);
    @(negedge clk); sof = 1'b0; eof = 1'b0;
    send_body(8'h67, 16'h1111, ref_crc(8'h67, 16'h1111), 0);
    end_check("R9 frame after sof+eof", 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_good();
    t_slow();
    t_crc_bad();
    t_short();
    t_long();
    t_restart();
    t_idle();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule